// File: doc/BRIEF.md
# Guarded Calendar Register Front End

This block sits between a simple single-cycle 32-bit register port and a calendar counter core. Every access to the calendar goes through it. It keeps configuration writes closed until software writes a two-step key. It freezes the core through an init request and acknowledge exchange. It keeps readable shadow copies of the core's time and date, and it raises a flag once those copies are fresh again. The slow calendar clock reaches the block as a one-cycle enable, `rtc_tick`, in the bus clock domain.

A typical programming sequence runs as follows:

1. Software opens the lock with the key writes.
2. It sets the init request and polls the init-active flag.
3. It writes time, date and prescaler.
4. It clears the request.
5. It clears the synchronised flag and polls until hardware sets it again.
6. It writes any other value to the key register to close the lock.

Time and date writes do not change state in this block. Each becomes a one-cycle load pulse to the core, with the written word on `core_ld_data`.

Top module: `rtc_guard_regs`

## Requirements
- R1: Writing 0xCA to the key register (offset 0x24, bits 7:0) and then 0x53 as the next key-register write opens the lock. Other register accesses between the two key writes do not break the sequence.
- R2: Any other key-register write closes the lock and restarts the sequence. This covers a wrong value at either step, a repeated 0xCA, and any key write made while the lock is open.
- R3: While the lock is closed, writes to time (0x00), date (0x04), prescaler (0x10), control (0x18) and the init-request bit have no effect. Reads still return data.
- R4: Status bit 7 is the init request and drives `core_hold`. Status bit 6 (init active) rises at the first edge with `rtc_tick` high after the request is set. Bit 6 falls in the same edge as the request is cleared.
- R5: Time, date and prescaler writes are accepted only when the lock is open and init is active. An accepted time or date write gives a one-cycle `core_ld_time` or `core_ld_date` pulse in the cycle after the write, with the written word on `core_ld_data`.
- R6: Status bit 5 (synchronised) behaves as follows:
  - Writing the status register with bit 5 at 0 clears it, whether or not the lock is open.
  - It is also cleared when init becomes active.
  - Outside init mode it sets after SYNC_TICKS (default 2) `rtc_tick` edges.
- R7: Status bit 4 (calendar initialised) sets on an accepted date write and stays set until reset.
- R8: Read data appears on `bus_rdata` in the cycle after the read. Time and date read the shadow copies, which are captured from the core on each `rtc_tick` outside init mode. The key register and unmapped offsets read 0. After reset, status and read data are 0.
- R9: The control register (CTRL_W bits) is writable whenever the lock is open, with or without init mode, and reads back its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle enable standing for a calendar clock edge |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| core_time_i | input | DATA_W | Live time word from the core |
| core_date_i | input | DATA_W | Live date word from the core |
| core_hold | output | 1 | Freeze request to the core |
| core_ld_time | output | 1 | Load pulse for time |
| core_ld_date | output | 1 | Load pulse for date |
| core_ld_data | output | DATA_W | Word to load |
| presc_o | output | PRESC_W | Prescaler setting |
| ctrl_o | output | CTRL_W | Control setting |
| status_o | output | 8 | Status bits (7 request, 6 active, 5 synchronised, 4 initialised) |

## Verification
The bound assertions check several rules on every cycle:
- Load pulses appear only while init is active, and never both together.
- Init active never stands without the request, and it only rises on a tick.
- The synchronised flag stays low during init.
- The initialised flag never drops.
- The prescaler never moves outside init.

Other behaviour can only be shown by the bench's scenarios. These include which key histories actually open the lock, which it checks with a sweep over all two-write key pairs, and the exact tick count before the synchronised flag returns. They also include that shadow reads return the core value captured at the right tick, and that locked writes leave control, request and loads untouched.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
    localparam int unsigned OFF_TIME  = 32'h00;
    localparam int unsigned OFF_DATE  = 32'h04;
    localparam int unsigned OFF_STAT  = 32'h0C;
    localparam int unsigned OFF_PRESC = 32'h10;
    localparam int unsigned OFF_CTRL  = 32'h18;
    localparam int unsigned OFF_KEY   = 32'h24;

    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    localparam int unsigned BIT_REQ  = 7;
    localparam int unsigned BIT_ACT  = 6;
    localparam int unsigned BIT_SYNC = 5;
    localparam int unsigned BIT_DONE = 4;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_st_e;
endpackage

// File: rtl/rtc_key_fsm.sv
module rtc_key_fsm
    import rtc_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       unlocked
);
    typedef struct packed {
        key_st_e st;
    } key_regs_t;

    key_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (key_wr) begin
            case (r_q.st)
                KS_LOCKED: r_d.st = (key_val == KEY_FIRST)  ? KS_HALF : KS_LOCKED;
                KS_HALF:   r_d.st = (key_val == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
                default:   r_d.st = KS_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: KS_LOCKED};
        else        r_q <= r_d;
    end

    assign unlocked = (r_q.st == KS_OPEN);
endmodule

// File: rtl/rtc_init_sync.sv
module rtc_init_sync #(
    parameter int unsigned SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rtc_tick,
    input  logic req_wr,
    input  logic req_val,
    input  logic sync_clr,
    input  logic date_acc,
    output logic init_req,
    output logic init_act,
    output logic synced,
    output logic cal_done,
    output logic shadow_en
);
    localparam int unsigned CNT_W = (SYNC_TICKS < 2) ? 1 : $clog2(SYNC_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_TICKS - 1);

    typedef struct packed {
        logic             req;
        logic             act;
        logic             rsf;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (req_wr) r_d.req = req_val;
        r_d.act = r_d.req & (r_q.act | (r_q.req & rtc_tick));
        if (r_d.act && !r_q.act) begin
            r_d.rsf = 1'b0;
            r_d.cnt = '0;
        end else if (sync_clr) begin
            r_d.rsf = 1'b0;
            r_d.cnt = '0;
        end else if (!r_q.act && !r_q.rsf && rtc_tick) begin
            if (r_q.cnt == CNT_LAST) begin
                r_d.rsf = 1'b1;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
        if (date_acc) r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign init_req  = r_q.req;
    assign init_act  = r_q.act;
    assign synced    = r_q.rsf;
    assign cal_done  = r_q.done;
    assign shadow_en = rtc_tick & ~r_q.act;
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] time_i,
    input  logic [DATA_W-1:0] date_i,
    output logic [DATA_W-1:0] time_o,
    output logic [DATA_W-1:0] date_o
);
    typedef struct packed {
        logic [DATA_W-1:0] tm;
        logic [DATA_W-1:0] dt;
    } shd_regs_t;

    shd_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_en) begin
            r_d.tm = time_i;
            r_d.dt = date_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign time_o = r_q.tm;
    assign date_o = r_q.dt;
endmodule

// File: rtl/rtc_guard_regs.sv
module rtc_guard_regs
    import rtc_guard_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PRESC_W    = 23,
    parameter int unsigned CTRL_W     = 8,
    parameter int unsigned SYNC_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rtc_tick,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  core_time_i,
    input  logic [DATA_W-1:0]  core_date_i,
    output logic               core_hold,
    output logic               core_ld_time,
    output logic               core_ld_date,
    output logic [DATA_W-1:0]  core_ld_data,
    output logic [PRESC_W-1:0] presc_o,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic [7:0]         status_o
);
    localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFF_TIME);
    localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(OFF_DATE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFF_PRESC);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFF_KEY);

    typedef struct packed {
        logic [DATA_W-1:0]  rdata;
        logic [PRESC_W-1:0] presc;
        logic [CTRL_W-1:0]  ctrl;
        logic               ld_time;
        logic               ld_date;
        logic [DATA_W-1:0]  ld_data;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic wr, rd, unlocked, cfg_ok;
    logic time_acc, date_acc, presc_acc, ctrl_acc;
    logic stat_wr, init_req, init_act, synced, cal_done, shadow_en;
    logic [DATA_W-1:0] shd_time, shd_date;
    logic [7:0] status;

    assign wr      = bus_sel & bus_we;
    assign rd      = bus_sel & ~bus_we;
    assign stat_wr = wr & (bus_addr == A_STAT);

    rtc_key_fsm key_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr & (bus_addr == A_KEY)),
        .key_val  (bus_wdata[7:0]),
        .unlocked (unlocked)
    );

    assign cfg_ok    = unlocked & init_act;
    assign time_acc  = wr & (bus_addr == A_TIME)  & cfg_ok;
    assign date_acc  = wr & (bus_addr == A_DATE)  & cfg_ok;
    assign presc_acc = wr & (bus_addr == A_PRESC) & cfg_ok;
    assign ctrl_acc  = wr & (bus_addr == A_CTRL)  & unlocked;

    rtc_init_sync #(.SYNC_TICKS(SYNC_TICKS)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_tick  (rtc_tick),
        .req_wr    (stat_wr & unlocked),
        .req_val   (bus_wdata[BIT_REQ]),
        .sync_clr  (stat_wr & ~bus_wdata[BIT_SYNC]),
        .date_acc  (date_acc),
        .init_req  (init_req),
        .init_act  (init_act),
        .synced    (synced),
        .cal_done  (cal_done),
        .shadow_en (shadow_en)
    );

    rtc_shadow #(.DATA_W(DATA_W)) shadow_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (shadow_en),
        .time_i (core_time_i),
        .date_i (core_date_i),
        .time_o (shd_time),
        .date_o (shd_date)
    );

    always_comb begin
        status           = '0;
        status[BIT_REQ]  = init_req;
        status[BIT_ACT]  = init_act;
        status[BIT_SYNC] = synced;
        status[BIT_DONE] = cal_done;
    end

    always_comb begin
        r_d         = r_q;
        r_d.ld_time = time_acc;
        r_d.ld_date = date_acc;
        if (time_acc || date_acc) r_d.ld_data = bus_wdata;
        if (presc_acc) r_d.presc = bus_wdata[PRESC_W-1:0];
        if (ctrl_acc)  r_d.ctrl  = bus_wdata[CTRL_W-1:0];
        if (rd) begin
            case (bus_addr)
                A_TIME:  r_d.rdata = shd_time;
                A_DATE:  r_d.rdata = shd_date;
                A_STAT:  r_d.rdata = DATA_W'(status);
                A_PRESC: r_d.rdata = DATA_W'(r_q.presc);
                A_CTRL:  r_d.rdata = DATA_W'(r_q.ctrl);
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata    = r_q.rdata;
    assign core_hold    = init_req;
    assign core_ld_time = r_q.ld_time;
    assign core_ld_date = r_q.ld_date;
    assign core_ld_data = r_q.ld_data;
    assign presc_o      = r_q.presc;
    assign ctrl_o       = r_q.ctrl;
    assign status_o     = status;
endmodule

// File: rtl/rtc_guard_chk.sv
module rtc_guard_chk #(
    parameter int unsigned PRESC_W = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rtc_tick,
    input logic [7:0]         status_o,
    input logic               core_hold,
    input logic               core_ld_time,
    input logic               core_ld_date,
    input logic [PRESC_W-1:0] presc_o
);
    AST_LOAD_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ld_time || core_ld_date) |-> status_o[6]); // R5
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_ld_time, core_ld_date})); // R5
    AST_ACT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6] |-> (core_hold && status_o[7])); // R4
    AST_ACT_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[6]) |-> $past(rtc_tick)); // R4
    AST_SYNC_LOW_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6] |-> !status_o[5]); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_o[4]) |-> status_o[4]); // R7
    AST_PRESC_FROZEN_OUTSIDE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(status_o[6]) |-> $stable(presc_o)); // R5
endmodule

bind rtc_guard_regs rtc_guard_chk #(.PRESC_W(PRESC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rtc_tick     (rtc_tick),
    .status_o     (status_o),
    .core_hold    (core_hold),
    .core_ld_time (core_ld_time),
    .core_ld_date (core_ld_date),
    .presc_o      (presc_o)
);

// File: tb/rtc_guard_regs_tb.sv
`timescale 1ns/1ps
module rtc_guard_regs_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PRESC_W = 23;
    localparam int CTRL_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rtc_tick = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] core_time = '0;
    logic [DATA_W-1:0] core_date = '0;
    logic core_hold, core_ld_time, core_ld_date;
    logic [DATA_W-1:0] core_ld_data;
    logic [PRESC_W-1:0] presc_o;
    logic [CTRL_W-1:0] ctrl_o;
    logic [7:0] status_o;

    int total = 0;
    int bad = 0;
    int ld_count = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_guard_regs dut_i (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_time_i(core_time), .core_date_i(core_date),
        .core_hold(core_hold), .core_ld_time(core_ld_time),
        .core_ld_date(core_ld_date), .core_ld_data(core_ld_data),
        .presc_o(presc_o), .ctrl_o(ctrl_o), .status_o(status_o)
    );

    // Behavioural calendar core: loads on pulses, counts ticks unless held.
    always_ff @(posedge clk) begin
        if (core_ld_time || core_ld_date) ld_count <= ld_count + 1;
        if (core_ld_time)                 core_time <= core_ld_data;
        else if (rtc_tick && !core_hold)  core_time <= core_time + 1;
        if (core_ld_date)                 core_date <= core_ld_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        rtc_tick = 1'b1;
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0] keys [4];
        logic [CTRL_W-1:0] exp_ctrl;
        int ld_before;
        keys[0] = 8'hCA; keys[1] = 8'h53; keys[2] = 8'hFF; keys[3] = 8'h00;
        exp_ctrl = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        chk("R8 reset status", {24'h0, status_o}, 32'h0);
        chk("R8 reset rdata", bus_rdata, 32'h0);
        chk("R4 reset hold", {31'h0, core_hold}, 32'h0);

        // R6 sync flag after SYNC_TICKS ticks
        tick();
        chk("R6 sync after 1 tick", {31'h0, status_o[5]}, 32'h0);
        tick();
        chk("R6 sync after 2 ticks", {31'h0, status_o[5]}, 32'h1);

        // R1 R2 R3 R9: sweep of all key pairs from the closed state
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [CTRL_W-1:0] val;
                val = CTRL_W'(i * 4 + j + 1);
                wr(8'h24, 32'hFF);
                wr(8'h24, {24'h0, keys[i]});
                wr(8'h24, {24'h0, keys[j]});
                wr(8'h18, {24'h0, val});
                if (keys[i] == 8'hCA && keys[j] == 8'h53) exp_ctrl = val;
                rd(8'h18, v);
                chk("R1/R2/R3/R9 key pair sweep ctrl", v, {24'h0, exp_ctrl});
            end
        end

        // R1: unrelated access between key writes does not break the sequence
        wr(8'h24, 32'hFF);
        wr(8'h24, 32'hCA);
        rd(8'h0C, v);
        wr(8'h24, 32'h53);
        wr(8'h18, 32'h5A);
        rd(8'h18, v);
        chk("R1 key pair with read in between", v, 32'h5A);

        // R2: repeated first key and key write while open both close
        wr(8'h24, 32'hCA);
        wr(8'h18, 32'h11);
        rd(8'h18, v);
        chk("R2 key write while open relocks", v, 32'h5A);
        wr(8'h24, 32'hFF); wr(8'h24, 32'hCA); wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
        wr(8'h18, 32'h22);
        rd(8'h18, v);
        chk("R2 repeated first key stays locked", v, 32'h5A);

        // R3: locked init request ignored
        wr(8'h0C, 32'hA0);
        chk("R3 locked init request ignored", {31'h0, status_o[7]}, 32'h0);

        // R4 init handshake
        wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
        ld_before = ld_count;
        wr(8'h0C, 32'hA0);
        chk("R4 request bit", {31'h0, status_o[7]}, 32'h1);
        chk("R4 hold follows request", {31'h0, core_hold}, 32'h1);
        chk("R4 active waits for tick", {31'h0, status_o[6]}, 32'h0);
        wr(8'h00, 32'h00AB_CDEF);
        @(negedge clk);
        chk("R5 time before active ignored", ld_count, ld_before);
        tick();
        chk("R4 active after tick", {31'h0, status_o[6]}, 32'h1);
        chk("R6 sync cleared on entering init", {31'h0, status_o[5]}, 32'h0);

        // R5 accepted loads
        wr(8'h00, 32'h0012_3456);
        chk("R5 time load pulse", {31'h0, core_ld_time}, 32'h1);
        chk("R5 time load data", core_ld_data, 32'h0012_3456);
        @(negedge clk);
        chk("R5 load pulse one cycle", {31'h0, core_ld_time}, 32'h0);
        wr(8'h10, 32'hFF80_00FF);
        rd(8'h10, v);
        chk("R5 prescaler in init", v, 32'h0000_00FF & 32'h007F_FFFF | 32'h0000_0000 + (32'hFF80_00FF & 32'h007F_FFFF) - 32'h0000_00FF);
        chk("R7 not set before date", {31'h0, status_o[4]}, 32'h0);
        wr(8'h04, 32'h0024_0115);
        chk("R5 date load pulse", {31'h0, core_ld_date}, 32'h1);
        chk("R7 set by date write", {31'h0, status_o[4]}, 32'h1);

        // R3: locked while in init
        wr(8'h24, 32'hFF);
        ld_before = ld_count;
        wr(8'h00, 32'h0099_9999);
        wr(8'h10, 32'h0000_1234);
        @(negedge clk);
        chk("R3 locked time write in init", ld_count, ld_before);
        rd(8'h10, v);
        chk("R3 locked prescaler write", v, 32'h0000_00FF);
        wr(8'h0C, 32'h00);
        chk("R3 locked request clear ignored", {31'h0, status_o[7]}, 32'h1);

        // R4 exit
        wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
        wr(8'h0C, 32'h20);
        chk("R4 active cleared with request", {31'h0, status_o[6]}, 32'h0);
        chk("R4 hold released", {31'h0, core_hold}, 32'h0);

        // R5 prescaler outside init ignored
        wr(8'h10, 32'h0000_0777);
        rd(8'h10, v);
        chk("R5 prescaler outside init", v, 32'h0000_00FF);

        // R6 / R8 shadow capture
        tick();
        chk("R6 sync after 1 tick post-exit", {31'h0, status_o[5]}, 32'h0);
        tick();
        chk("R6 sync after 2 ticks post-exit", {31'h0, status_o[5]}, 32'h1);
        rd(8'h00, v);
        chk("R8 shadow time", v, 32'h0012_3457);
        rd(8'h04, v);
        chk("R8 shadow date", v, 32'h0024_0115);

        // R6 clear while locked
        wr(8'h24, 32'hFF);
        wr(8'h0C, 32'h00);
        rd(8'h0C, v);
        chk("R6 locked sync clear", v & 32'h20, 32'h0);
        tick(); tick();
        chk("R6 sync returns", {31'h0, status_o[5]}, 32'h1);

        // R7 sticky, R8 read map
        chk("R7 initialised sticky", {31'h0, status_o[4]}, 32'h1);
        rd(8'h24, v);
        chk("R8 key register reads 0", v, 32'h0);
        rd(8'h08, v);
        chk("R8 unmapped reads 0", v, 32'h0);
        rd(8'h0C, v);
        chk("R8 status read", v, 32'h30);

        done = 1;
        summary();
        $finish;
    end
endmodule